// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block pulls one instruction at a time out of a program memory organised as 16-bit words. It starts from the current program counter. It looks at the top byte of the first word and decides how long the instruction is. A register-format instruction occupies a single word. A memory-format instruction occupies two words: the high word sits at the PC and the low word at PC+1. It also recognises a halt code and catches any opcode outside the defined set.

For a memory-format instruction, the block reads the index register named in the first word from the register file. It adds the 16-bit displacement, taken from the second word, to that register's value, and the sum is the effective address.

The decoded fields, the assembled instruction register and the advanced PC are all registered together. A one-cycle done pulse marks the moment they become valid. A neighbouring execute stage consumes these fields; this block does not execute anything. An undefined opcode raises a sticky error flag, freezes the PC and blocks further fetches until reset.

Top module: `ifetch_dec`

## Requirements
- R1: After reset the PC equals `RESET_PC` (default 0), and `done`, `illegal` and `mem_rd_en` are all low.
- R2: A `start` seen in the idle state with no error present drives `mem_rd_en` with `mem_addr` equal to the PC in that same cycle. Read data comes back on `mem_rdata` one cycle later. For a two-word instruction, a second read at PC+1 is issued in the cycle the first word arrives.
- R3: The opcode is the first word's bits 15:8. The legal set is 0x00–0x05, 0x10, 0x11, 0x13, 0x14, 0x20–0x25, 0x33, 0x34, 0x80–0x86, 0x93–0x96 and 0x99. The one-word codes are 0x20–0x25, 0x33, 0x34 and 0x99; every other legal code is two words long, and `is_long` reports which.
- R4: For a one-word register-format instruction, `ir` is the word zero-extended to 32 bits. `reg_a` comes from bits 7:4 and `reg_b` from bits 3:0, and both are flagged valid. `eff_addr` is 0 and not valid.
- R5: For a two-word instruction, `ir` is {high word, low word}. `reg_a` comes from `ir[23:20]` and is valid. `rf_rd_idx` presents `ir[19:16]` while the low word is received. `eff_addr` equals the zero-extended `ir[15:0]` plus the register value, modulo 2^32, and is valid. `reg_b` is 0 and not valid.
- R6: Opcode 0x99 is one word long and raises `is_halt`. It leaves all three field-valid flags low and `reg_a`, `reg_b` and `eff_addr` at 0.
- R7: On completion `done` is high for exactly one cycle, namely the cycle after the last word arrives. From that cycle on, the PC shows the old PC plus 1 for a one-word instruction or plus 2 for a two-word instruction.
- R8: An undefined opcode sets `illegal` and does not pulse `done`. The PC keeps its value. `illegal` stays high until reset, and later `start` requests issue no memory read.
- R9: A `start` held high during the `done` cycle launches the next fetch at the already advanced PC, so consecutive instructions are fetched back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to fetch and decode the instruction at the PC |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_addr | output | PCW | Program memory word address |
| mem_rdata | input | 16 | Word returned one cycle after the strobe |
| rf_rd_idx | output | 4 | Register file read index (index register) |
| rf_rd_data | input | DW | Register file read value, same cycle |
| pc | output | PCW | Program counter |
| ir | output | 32 | Instruction register |
| opcode | output | 8 | Decoded opcode |
| reg_a | output | 4 | First register field |
| reg_b | output | 4 | Second register field |
| eff_addr | output | DW | Effective address |
| reg_a_vld | output | 1 | `reg_a` is meaningful |
| reg_b_vld | output | 1 | `reg_b` is meaningful |
| eff_addr_vld | output | 1 | `eff_addr` is meaningful |
| is_long | output | 1 | Decoded instruction is two words long |
| is_halt | output | 1 | Decoded instruction is the halt code |
| done | output | 1 | One-cycle pulse: decoded outputs updated |
| illegal | output | 1 | Sticky undefined-opcode flag |

## Verification
Two events can fall in the same cycle: the completion of one instruction (PC update and `done` pulse) and the acceptance of the next `start`. The bench provokes this by holding `start` high through a short program that mixes one-word, two-word and halt instructions, so every new fetch is requested exactly when the previous one completes. It judges the outcome by checking that each fetch reads from the freshly advanced PC, and that the PC sequence at each `done` is 1, 3, 4, 5. It also checks that the trailing undefined opcode stops the stream, with the PC frozen and no further reads.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    localparam int IW   = 16;   // program memory word width
    localparam int OPW  = 8;    // opcode field width
    localparam int RIW  = 4;    // register index width

    typedef enum logic [1:0] {
        FD_IDLE = 2'd0,
        FD_HI   = 2'd1,
        FD_LO   = 2'd2
    } fd_state_e;

    typedef struct packed {
        logic legal;
        logic long_fmt;
        logic halt;
    } op_info_t;

    function automatic op_info_t classify(input logic [OPW-1:0] op);
        op_info_t r;
        logic one_word;
        r.halt   = (op == 8'h99);
        one_word = (op >= 8'h20 && op <= 8'h25) || op == 8'h33 || op == 8'h34 || r.halt;
        r.legal  = (op <= 8'h05) || op == 8'h10 || op == 8'h11 || op == 8'h13 ||
                   op == 8'h14 || (op >= 8'h80 && op <= 8'h86) ||
                   (op >= 8'h93 && op <= 8'h96) || one_word;
        r.long_fmt = r.legal && !one_word;
        return r;
    endfunction

endpackage

// File: rtl/ifetch_opclass.sv
module ifetch_opclass
    import ifetch_pkg::*;
(
    input  logic [OPW-1:0] op,
    output logic           legal,
    output logic           long_fmt,
    output logic           halt
);
    op_info_t info;

    always_comb begin
        info     = classify(op);
        legal    = info.legal;
        long_fmt = info.long_fmt;
        halt     = info.halt;
    end
endmodule

// File: rtl/ifetch_fields.sv
module ifetch_fields
    import ifetch_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [IW-1:0]    hi_word,
    input  logic [IW-1:0]    lo_word,
    input  logic [DW-1:0]    idx_val,
    input  logic             long_fmt,
    input  logic             halt,
    output logic [2*IW-1:0]  ir,
    output logic [OPW-1:0]   opcode,
    output logic [RIW-1:0]   reg_a,
    output logic [RIW-1:0]   reg_b,
    output logic [DW-1:0]    eff_addr,
    output logic             reg_a_vld,
    output logic             reg_b_vld,
    output logic             eff_addr_vld
);
    logic [DW-1:0] disp_ext;

    generate
        if (DW > IW) begin : g_wide
            assign disp_ext = {{(DW-IW){1'b0}}, lo_word};
        end else begin : g_narrow
            assign disp_ext = lo_word[DW-1:0];
        end
    endgenerate

    always_comb begin
        ir           = long_fmt ? {hi_word, lo_word} : {{IW{1'b0}}, hi_word};
        opcode       = hi_word[IW-1 -: OPW];
        reg_a        = halt ? '0 : hi_word[2*RIW-1 -: RIW];
        reg_b        = (halt || long_fmt) ? '0 : hi_word[RIW-1:0];
        eff_addr     = long_fmt ? disp_ext + idx_val : '0;
        reg_a_vld    = !halt;
        reg_b_vld    = !halt && !long_fmt;
        eff_addr_vld = long_fmt;
    end
endmodule

// File: rtl/ifetch_dec.sv
module ifetch_dec
    import ifetch_pkg::*;
#(
    parameter int              PCW      = 16,
    parameter int              DW       = 32,
    parameter logic [PCW-1:0]  RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [PCW-1:0]    mem_addr,
    input  logic [IW-1:0]     mem_rdata,
    output logic [RIW-1:0]    rf_rd_idx,
    input  logic [DW-1:0]     rf_rd_data,
    output logic [PCW-1:0]    pc,
    output logic [2*IW-1:0]   ir,
    output logic [OPW-1:0]    opcode,
    output logic [RIW-1:0]    reg_a,
    output logic [RIW-1:0]    reg_b,
    output logic [DW-1:0]     eff_addr,
    output logic              reg_a_vld,
    output logic              reg_b_vld,
    output logic              eff_addr_vld,
    output logic              is_long,
    output logic              is_halt,
    output logic              done,
    output logic              illegal
);
    localparam int IRW = 2 * IW;
    localparam logic [PCW-1:0] STEP_SHORT = PCW'(1);
    localparam logic [PCW-1:0] STEP_LONG  = PCW'(2);

    typedef struct packed {
        fd_state_e       st;
        logic [PCW-1:0]  pc;
        logic [IW-1:0]   hold;
        logic [IRW-1:0]  ir;
        logic [OPW-1:0]  op;
        logic [RIW-1:0]  ra;
        logic [RIW-1:0]  rb;
        logic [DW-1:0]   ea;
        logic            ra_v;
        logic            rb_v;
        logic            ea_v;
        logic            lng;
        logic            halt;
        logic            done;
        logic            err;
    } regs_t;

    regs_t d, q;

    // first word is live memory data in the HI cycle, held copy afterwards
    logic [IW-1:0]  hi_w;
    logic           c_legal, c_long, c_halt;
    logic [IRW-1:0] f_ir;
    logic [OPW-1:0] f_op;
    logic [RIW-1:0] f_ra, f_rb;
    logic [DW-1:0]  f_ea;
    logic           f_ra_v, f_rb_v, f_ea_v;

    assign hi_w      = (q.st == FD_LO) ? q.hold : mem_rdata;
    assign rf_rd_idx = q.hold[RIW-1:0];

    ifetch_opclass u_cls (
        .op       (hi_w[IW-1 -: OPW]),
        .legal    (c_legal),
        .long_fmt (c_long),
        .halt     (c_halt)
    );

    ifetch_fields #(.DW(DW)) u_fld (
        .hi_word      (hi_w),
        .lo_word      (mem_rdata),
        .idx_val      (rf_rd_data),
        .long_fmt     (c_long),
        .halt         (c_halt),
        .ir           (f_ir),
        .opcode       (f_op),
        .reg_a        (f_ra),
        .reg_b        (f_rb),
        .eff_addr     (f_ea),
        .reg_a_vld    (f_ra_v),
        .reg_b_vld    (f_rb_v),
        .eff_addr_vld (f_ea_v)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        mem_rd_en = 1'b0;
        mem_addr  = q.pc;
        unique case (q.st)
            FD_IDLE: begin
                if (start && !q.err) begin
                    mem_rd_en = 1'b1;
                    d.st      = FD_HI;
                end
            end
            FD_HI: begin
                if (!c_legal) begin
                    d.err = 1'b1;
                    d.st  = FD_IDLE;
                end else if (c_long) begin
                    d.hold    = mem_rdata;
                    mem_rd_en = 1'b1;
                    mem_addr  = q.pc + STEP_SHORT;
                    d.st      = FD_LO;
                end
            end
            FD_LO: ;
            default: d.st = FD_IDLE;
        endcase

        // commit a completed instruction
        if ((q.st == FD_HI && c_legal && !c_long) || q.st == FD_LO) begin
            d.ir   = f_ir;
            d.op   = f_op;
            d.ra   = f_ra;
            d.rb   = f_rb;
            d.ea   = f_ea;
            d.ra_v = f_ra_v;
            d.rb_v = f_rb_v;
            d.ea_v = f_ea_v;
            d.lng  = c_long;
            d.halt = c_halt;
            d.pc   = q.pc + (c_long ? STEP_LONG : STEP_SHORT);
            d.done = 1'b1;
            d.st   = FD_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= FD_IDLE;
            q.pc <= RESET_PC;
        end else begin
            q <= d;
        end
    end

    assign pc           = q.pc;
    assign ir           = q.ir;
    assign opcode       = q.op;
    assign reg_a        = q.ra;
    assign reg_b        = q.rb;
    assign eff_addr     = q.ea;
    assign reg_a_vld    = q.ra_v;
    assign reg_b_vld    = q.rb_v;
    assign eff_addr_vld = q.ea_v;
    assign is_long      = q.lng;
    assign is_halt      = q.halt;
    assign done         = q.done;
    assign illegal      = q.err;

    // ---------------- assertions ----------------
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    a_r8_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(pc));

    a_r8_no_read_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_rd_en);

    a_r8_no_done_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !done);

    a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> pc == $past(pc) + (is_long ? STEP_LONG : STEP_SHORT));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_halt_no_fields: assert property (@(posedge clk) disable iff (!rst_n)
        is_halt |-> !(reg_a_vld || reg_b_vld || eff_addr_vld));

    a_r3_format_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_b_vld, eff_addr_vld}) <= 1);

    a_r2_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FD_HI && mem_rd_en) |-> mem_addr == pc + STEP_SHORT);

endmodule

// File: tb/ifetch_dec_tb.sv
module ifetch_dec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic [15:0] pc;
    logic [31:0] ir;
    logic [7:0]  opcode;
    logic [3:0]  reg_a, reg_b;
    logic [31:0] eff_addr;
    logic        reg_a_vld, reg_b_vld, eff_addr_vld, is_long, is_halt, done, illegal;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ifetch_dec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .pc(pc), .ir(ir), .opcode(opcode), .reg_a(reg_a), .reg_b(reg_b),
        .eff_addr(eff_addr), .reg_a_vld(reg_a_vld), .reg_b_vld(reg_b_vld),
        .eff_addr_vld(eff_addr_vld), .is_long(is_long), .is_halt(is_halt),
        .done(done), .illegal(illegal)
    );

    // program memory model: one-cycle read latency
    logic [15:0] mem [0:255];
    logic [15:0] rd_log [0:7];
    int          rd_n = 0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[7:0]];
            if (rd_n < 8) rd_log[rd_n] <= mem_addr;
            rd_n <= rd_n + 1;
        end
    end

    function automatic logic [31:0] rf_val(input logic [3:0] i);
        return 32'hFFFF_FF00 - {i, 28'h0};
    endfunction

    assign rf_rd_data = rf_val(rf_rd_idx);

    function automatic bit op_legal(input int op);
        return (op <= 5) || op == 'h10 || op == 'h11 || op == 'h13 || op == 'h14 ||
               (op >= 'h20 && op <= 'h25) || op == 'h33 || op == 'h34 ||
               (op >= 'h80 && op <= 'h86) || (op >= 'h93 && op <= 'h96) || op == 'h99;
    endfunction

    function automatic bit op_short(input int op);
        return (op >= 'h20 && op <= 'h25) || op == 'h33 || op == 'h34 || op == 'h99;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_n  = 0;
        @(negedge clk);
    endtask

    // wait for completion or error, sampling at negedge
    task automatic wait_end(output bit saw_done);
        saw_done = 0;
        for (int k = 0; k < 12; k++) begin
            if (done) begin saw_done = 1; break; end
            if (illegal) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit sd;
        logic [15:0] w0, w1;
        logic [3:0]  ra, ix;
        logic [31:0] exp_ea;

        for (int i = 0; i < 256; i++) mem[i] = 16'h0;

        // R1: reset state
        do_reset();
        check(pc == 16'h0, "R1 pc after reset", pc, 0);
        check(!done && !illegal && !mem_rd_en, "R1 flags after reset",
              {done, illegal, mem_rd_en}, 0);

        // R2..R8: sweep every opcode value
        for (int op = 0; op < 256; op++) begin
            ra = op[7:4];
            ix = op[3:0] ^ 4'h5;
            w0 = {op[7:0], ra, ix};
            w1 = 16'(op * 257 + 3);
            mem[0] = w0;
            mem[1] = w1;
            do_reset();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_end(sd);
            if (!op_legal(op)) begin
                check(illegal && !sd, "R8 illegal flagged without done", {illegal, sd}, 2);
                check(pc == 16'h0, "R8 pc unchanged on illegal", pc, 0);
                repeat (2) @(negedge clk);
                check(illegal, "R8 illegal sticky", illegal, 1);
            end else if (op_short(op)) begin
                check(sd && !illegal, "R7 done for short op", {sd, illegal}, 2);
                check(pc == 16'h1, "R7 pc +1 short", pc, 1);
                check(rd_n == 1 && rd_log[0] == 16'h0, "R2 single read at pc", rd_n, 1);
                check(ir == {16'h0, w0}, "R4 ir short", ir, {16'h0, w0});
                check(opcode == op[7:0] && !is_long, "R3 opcode/len short", opcode, op);
                if (op == 'h99) begin
                    check(is_halt && !reg_a_vld && !reg_b_vld && !eff_addr_vld &&
                          reg_a == 0 && reg_b == 0 && eff_addr == 0,
                          "R6 halt fields", {reg_a_vld, reg_b_vld, eff_addr_vld}, 0);
                end else begin
                    check(!is_halt && reg_a == ra && reg_b == ix && reg_a_vld && reg_b_vld &&
                          !eff_addr_vld && eff_addr == 0, "R4 register fields",
                          {reg_a, reg_b}, {ra, ix});
                end
            end else begin
                exp_ea = {16'h0, w1} + rf_val(ix);   // wraps modulo 2^32 (op 0x05)
                check(sd && !illegal, "R7 done for long op", {sd, illegal}, 2);
                check(pc == 16'h2, "R7 pc +2 long", pc, 2);
                check(rd_n == 2 && rd_log[0] == 16'h0 && rd_log[1] == 16'h1,
                      "R2 two reads pc, pc+1", rd_n, 2);
                check(ir == {w0, w1}, "R5 ir long", ir, {w0, w1});
                check(opcode == op[7:0] && is_long && !is_halt, "R3 opcode/len long", opcode, op);
                check(reg_a == ra && reg_a_vld && !reg_b_vld && reg_b == 0,
                      "R5 register field long", reg_a, ra);
                check(eff_addr == exp_ea && eff_addr_vld, "R5 effective address",
                      eff_addr, exp_ea);
            end
            // one-cycle pulse
            @(negedge clk);
            check(!done, "R7 done is one cycle", done, 0);
        end

        // R9: back-to-back stream with start held high
        mem[0] = 16'h2312;
        mem[1] = 16'h0101; mem[2] = 16'h0010;
        mem[3] = 16'h3445;
        mem[4] = 16'h9900;
        mem[5] = 16'hFF00;
        do_reset();
        start = 1'b1;
        begin
            logic [15:0] exp_pc [0:3];
            int          got = 0;
            exp_pc[0] = 16'd1; exp_pc[1] = 16'd3; exp_pc[2] = 16'd4; exp_pc[3] = 16'd5;
            for (int k = 0; k < 40 && got < 4; k++) begin
                if (done) begin
                    check(pc == exp_pc[got], "R9 pc at each done", pc, exp_pc[got]);
                    if (got == 1)
                        check(eff_addr == 32'hEFFF_FF10, "R9 long ea in stream",
                              eff_addr, 32'hEFFF_FF10);
                    got++;
                end
                @(negedge clk);
            end
            check(got == 4, "R9 four completions", got, 4);
            check(rd_n == 6 && rd_log[0] == 0 && rd_log[1] == 1 && rd_log[2] == 2 &&
                  rd_log[3] == 3 && rd_log[4] == 4, "R9 read address sequence", rd_n, 6);
        end
        for (int k = 0; k < 6 && !illegal; k++) @(negedge clk);
        check(illegal && pc == 16'd5, "R8 stream stops on illegal", pc, 5);
        begin
            int reads = 0;
            for (int k = 0; k < 6; k++) begin
                if (mem_rd_en) reads++;
                @(negedge clk);
            end
            check(reads == 0 && pc == 16'd5, "R8 start ignored after error", reads, 0);
        end
        start = 1'b0;

        // R1: reset clears the error
        do_reset();
        check(!illegal && pc == 16'h0, "R1 reset clears error", illegal, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule